// File: doc/BRIEF.md
# Four-Pixel Region Hit Buffer with Time-over-Threshold

This block is the digital logic shared by a cluster of four neighbouring pixels. Each pixel delivers a discriminator level that is already synchronous to the block clock. A rising level marks the start of a hit and a falling level marks its end. The number of clock cycles for which the level stays high is the hit's time-over-threshold (ToT). Every hit is kept in one of a few local storage slots for as long as the trigger decision takes. Data never moves along the column while it waits.

When a hit starts, the block claims a slot and loads that slot's own latency countdown from the configuration input. When the countdown runs out, the slot samples the trigger input once. If the trigger is present, the slot holds its pixel mask and ToT fields and offers them on the read port until the reader acknowledges them. If the trigger is absent, the slot is released at once. Hits from several pixels that start in the same cycle share one slot. A hit that finds every slot occupied is dropped and reported on an overflow flag.

Top module: `pixreg_hitbuf`

## Requirements
- R1: During and right after reset, `rd_ready_o` and `overflow_o` are low and no slot holds data.
- R2: A pixel whose discriminator is sampled high for N consecutive cycles gets ToT = N in its 4-bit field, saturating at 15.
- R3: A starting hit takes the free slot with the lowest index. Slot indices run from 0 to NSLOT-1.
- R4: Hits in different pixels that start on the same cycle share one slot. The mask bit of each of those pixels is set, and each pixel has its own ToT field.
- R5: Suppose a hit's rising level is first sampled at clock edge e, with latency L on `lat_cfg_i` at that edge. The trigger is then sampled only at edge e+L+1. If it is high there, the slot is shown on the read port from that edge on.
- R6: A slot whose trigger sample is low is freed without ever asserting `rd_ready_o`.
- R7: A ready slot keeps its data until `rd_ack_i` is high while that slot is shown. The slot is free from the next edge on.
- R8: When several slots are ready, the port shows the one with the lowest slot index, whichever slot became ready first.
- R9: If a hit starts while all NSLOT slots are occupied, it is dropped and `overflow_o` is high in the following cycle. Its later falling level changes no stored data.
- R10: A pixel whose level is still high when its slot's trigger is sampled is stored with ToT 15.
- R11: The latency is captured when the hit starts. Later changes on `lat_cfg_i` do not move that slot's trigger sample.
- R12: On the read port, `rd_mask_o` bit p flags pixel p. Bits [4p+3:4p] of `rd_tot_o` hold pixel p's ToT. Pixels not in the mask read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disc_i | input | 4 | Synchronous discriminator level, one bit per pixel |
| trigger_i | input | 1 | Trigger level, sampled when a slot's latency expires |
| lat_cfg_i | input | 8 | Trigger latency in cycles, captured at hit start |
| rd_ready_o | output | 1 | A triggered slot is shown on the read port |
| rd_mask_o | output | 4 | Pixel mask of the shown slot |
| rd_tot_o | output | 16 | ToT fields of the shown slot, 4 bits per pixel |
| rd_ack_i | input | 1 | Reader takes the shown slot this cycle |
| overflow_o | output | 1 | One cycle flag: a hit was dropped for lack of a slot |

## Verification
The assertions assume that `disc_i` is already synchronous to `clk_i`. They also assume that `rd_ack_i` is only raised while `rd_ready_o` is high, because a slot may only be released from the ready state. The bench drives every input half a cycle away from the active edge. It raises the acknowledge only in cycles where it has just seen the port ready. It holds each discriminator level for whole cycles, so that each rising and falling level gives exactly one start and one end event.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_PEND  = 2'd1,
      SLOT_READY = 2'd2
   } slot_state_e;

endpackage

// File: rtl/pixreg_pick.sv
module pixreg_pick #(
   parameter int unsigned WIDTH = 5
) (
   input  logic [WIDTH-1:0] req_i,
   output logic [WIDTH-1:0] gnt_o,
   output logic             any_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("pixreg_pick: WIDTH must be at least 1");
   end

   logic [WIDTH:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_chain
      assign gnt_o[i]  = req_i[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req_i[i];
   end

   assign any_o = seen[WIDTH];

endmodule

// File: rtl/pixreg_tot.sv
module pixreg_tot #(
   parameter int unsigned TOTW = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            disc_i,
   output logic            lead_o,
   output logic            trail_o,
   output logic [TOTW-1:0] tot_o
);

   localparam logic [TOTW-1:0] TOT_MAX = {TOTW{1'b1}};

   if (TOTW < 2) begin : g_bad_totw
      $error("pixreg_tot: TOTW must be at least 2");
   end

   logic            disc_q;
   logic [TOTW-1:0] cnt_q;

   assign lead_o  = disc_i & ~disc_q;
   assign trail_o = ~disc_i & disc_q;
   assign tot_o   = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         disc_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         disc_q <= disc_i;
         if (lead_o) begin
            cnt_q <= {{(TOTW-1){1'b0}}, 1'b1};
         end else if (disc_i && (cnt_q != TOT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R2
   tot_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disc_q |-> (cnt_q != '0));

   // R2
   tot_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disc_q && disc_i && cnt_q == TOT_MAX) |=> (cnt_q == TOT_MAX));

endmodule

// File: rtl/pixreg_slot.sv
module pixreg_slot
   import pixreg_pkg::*;
#(
   parameter int unsigned NPIX = 4,
   parameter int unsigned TOTW = 4,
   parameter int unsigned LATW = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 alloc_i,
   input  logic [NPIX-1:0]      lead_i,
   input  logic [LATW-1:0]      lat_i,
   input  logic [NPIX-1:0]      trail_i,
   input  logic [NPIX*TOTW-1:0] tot_i,
   input  logic                 trigger_i,
   input  logic                 take_i,
   output logic                 free_o,
   output logic                 ready_o,
   output logic [NPIX-1:0]      mask_o,
   output logic [NPIX*TOTW-1:0] tot_o
);

   localparam logic [TOTW-1:0] TOT_MAX = {TOTW{1'b1}};

   if (LATW < 1) begin : g_bad_latw
      $error("pixreg_slot: LATW must be at least 1");
   end

   slot_state_e                state_q;
   logic [LATW-1:0]            cnt_q;
   logic [NPIX-1:0]            mask_q;
   logic [NPIX-1:0]            open_q;
   logic [NPIX-1:0][TOTW-1:0]  tot_q;
   logic                       expire;

   assign expire  = (state_q == SLOT_PEND) && (cnt_q == '0);
   assign free_o  = (state_q == SLOT_FREE);
   assign ready_o = (state_q == SLOT_READY);
   assign mask_o  = mask_q;
   assign tot_o   = tot_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SLOT_FREE;
         cnt_q   <= '0;
         mask_q  <= '0;
         open_q  <= '0;
         tot_q   <= '0;
      end else begin
         unique case (state_q)
            SLOT_FREE: begin
               if (alloc_i) begin
                  state_q <= SLOT_PEND;
                  cnt_q   <= lat_i;
                  mask_q  <= lead_i;
                  open_q  <= lead_i;
                  tot_q   <= '0;
               end
            end
            SLOT_PEND: begin
               if (expire) begin
                  state_q <= trigger_i ? SLOT_READY : SLOT_FREE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
               for (int p = 0; p < NPIX; p++) begin
                  if (trail_i[p] && open_q[p]) begin
                     tot_q[p]  <= tot_i[p*TOTW +: TOTW];
                     open_q[p] <= 1'b0;
                  end else if (expire && open_q[p]) begin
                     tot_q[p]  <= TOT_MAX;
                     open_q[p] <= 1'b0;
                  end
               end
            end
            SLOT_READY: begin
               if (take_i) begin
                  state_q <= SLOT_FREE;
               end
            end
            default: state_q <= SLOT_FREE;
         endcase
      end
   end

   // R3
   alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_i |-> (state_q == SLOT_FREE));

   // R5
   pend_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SLOT_PEND && cnt_q != '0) |=> (state_q == SLOT_PEND));

   // R7
   ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SLOT_READY && !take_i) |=> (state_q == SLOT_READY));

   // R7
   take_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i |-> (state_q == SLOT_READY));

   // R10
   open_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != SLOT_PEND) |-> (open_q == '0));

endmodule

// File: rtl/pixreg_hitbuf.sv
module pixreg_hitbuf
   import pixreg_pkg::*;
#(
   parameter int unsigned NPIX  = 4,
   parameter int unsigned NSLOT = 5,
   parameter int unsigned TOTW  = 4,
   parameter int unsigned LATW  = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NPIX-1:0]      disc_i,
   input  logic                 trigger_i,
   input  logic [LATW-1:0]      lat_cfg_i,
   output logic                 rd_ready_o,
   output logic [NPIX-1:0]      rd_mask_o,
   output logic [NPIX*TOTW-1:0] rd_tot_o,
   input  logic                 rd_ack_i,
   output logic                 overflow_o
);

   localparam int unsigned DATW = NPIX * TOTW;

   if (NPIX < 1) begin : g_bad_npix
      $error("pixreg_hitbuf: NPIX must be at least 1");
   end
   if (NSLOT < 1) begin : g_bad_nslot
      $error("pixreg_hitbuf: NSLOT must be at least 1");
   end

   logic [NPIX-1:0]            lead;
   logic [NPIX-1:0]            trail;
   logic [DATW-1:0]            tot_now;
   logic                       any_lead;

   logic [NSLOT-1:0]           slot_free;
   logic [NSLOT-1:0]           slot_ready;
   logic [NSLOT-1:0]           alloc_gnt;
   logic [NSLOT-1:0]           alloc;
   logic [NSLOT-1:0]           rd_gnt;
   logic [NSLOT-1:0]           take;
   logic                       any_free;
   logic [NSLOT-1:0][NPIX-1:0] slot_mask;
   logic [NSLOT-1:0][DATW-1:0] slot_tot;
   logic                       ovf_q;

   for (genvar p = 0; p < NPIX; p++) begin : g_pix
      pixreg_tot #(.TOTW(TOTW)) u_tot (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .disc_i  (disc_i[p]),
         .lead_o  (lead[p]),
         .trail_o (trail[p]),
         .tot_o   (tot_now[p*TOTW +: TOTW])
      );
   end

   assign any_lead = |lead;

   pixreg_pick #(.WIDTH(NSLOT)) u_alloc_pick (
      .req_i (slot_free),
      .gnt_o (alloc_gnt),
      .any_o (any_free)
   );

   assign alloc = alloc_gnt & {NSLOT{any_lead}};

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      pixreg_slot #(
         .NPIX (NPIX),
         .TOTW (TOTW),
         .LATW (LATW)
      ) u_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .alloc_i   (alloc[s]),
         .lead_i    (lead),
         .lat_i     (lat_cfg_i),
         .trail_i   (trail),
         .tot_i     (tot_now),
         .trigger_i (trigger_i),
         .take_i    (take[s]),
         .free_o    (slot_free[s]),
         .ready_o   (slot_ready[s]),
         .mask_o    (slot_mask[s]),
         .tot_o     (slot_tot[s])
      );
   end

   pixreg_pick #(.WIDTH(NSLOT)) u_rd_pick (
      .req_i (slot_ready),
      .gnt_o (rd_gnt),
      .any_o (rd_ready_o)
   );

   assign take = rd_gnt & {NSLOT{rd_ack_i}};

   always_comb begin
      rd_mask_o = '0;
      rd_tot_o  = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (rd_gnt[s]) begin
            rd_mask_o = rd_mask_o | slot_mask[s];
            rd_tot_o  = rd_tot_o | slot_tot[s];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= any_lead & ~any_free;
      end
   end

   assign overflow_o = ovf_q;

   // R9
   ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overflow_o |-> $past(slot_free == '0));

   // R8
   rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_ready_o |-> ($countones(rd_gnt) == 1 && (rd_gnt & slot_ready) != '0));

   // R4
   one_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(alloc));

   // R12
   rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_ready_o |-> (rd_mask_o == '0 && rd_tot_o == '0));

endmodule

// File: tb/tb_pixreg_hitbuf.sv
module tb_pixreg_hitbuf;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  disc = '0;
   logic        trig = 1'b0;
   logic [7:0]  lat = '0;
   logic        rd_ready;
   logic [3:0]  rd_mask;
   logic [15:0] rd_tot;
   logic        rd_ack = 1'b0;
   logic        ovf;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   pixreg_hitbuf dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .disc_i     (disc),
      .trigger_i  (trig),
      .lat_cfg_i  (lat),
      .rd_ready_o (rd_ready),
      .rd_mask_o  (rd_mask),
      .rd_tot_o   (rd_tot),
      .rd_ack_i   (rd_ack),
      .overflow_o (ovf)
   );

   // fields: mask[20:17] len[16:9] lat[8:1] trig[0]
   localparam logic [20:0] VEC [0:7] = '{
      {4'b0001, 8'd3,  8'd4,  1'b1},
      {4'b0100, 8'd20, 8'd30, 1'b1},
      {4'b1000, 8'd2,  8'd5,  1'b0},
      {4'b0011, 8'd5,  8'd10, 1'b1},
      {4'b0010, 8'd9,  8'd3,  1'b1},
      {4'b1111, 8'd1,  8'd0,  1'b1},
      {4'b0010, 8'd6,  8'd5,  1'b1},
      {4'b0100, 8'd7,  8'd5,  1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_hit(input logic [3:0] m, input int n, input int l, input bit t);
      logic [15:0] et;
      int ev;
      int endk;
      ev   = (n <= l + 1) ? ((n > 15) ? 15 : n) : 15;
      et   = '0;
      for (int p = 0; p < 4; p++) begin
         if (m[p]) et[p*4 +: 4] = 4'(ev);
      end
      endk = ((n > l + 3) ? n : l + 3) + 1;
      for (int k = 0; k <= endk; k++) begin
         @(negedge clk);
         disc   = (k < n) ? m : 4'b0000;
         lat    = 8'(l);
         trig   = (t && k == l + 1);
         rd_ack = 1'b0;
         if (k <= l + 1) chk("R5 no early ready", {31'd0, rd_ready}, 32'd0);
         if (k == l + 2) begin
            chk(t ? "R5 ready after latency" : "R6 untriggered never ready",
                {31'd0, rd_ready}, {31'd0, t});
            if (t) begin
               chk("R4 R12 mask", {28'd0, rd_mask}, {28'd0, m});
               chk("R2 R10 R12 tot", {16'd0, rd_tot}, {16'd0, et});
               rd_ack = 1'b1;
            end
         end
         if (k == l + 3) chk("R7 ack frees slot", {31'd0, rd_ready}, 32'd0);
      end
      @(negedge clk);
      disc = '0; trig = 1'b0; rd_ack = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", {31'd0, rd_ready}, 32'd0);
      chk("R1 overflow in reset", {31'd0, ovf}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", {31'd0, rd_ready}, 32'd0);
      chk("R1 mask after reset", {28'd0, rd_mask}, 32'd0);

      // table walk: R2 R4 R5 R6 R10 R12
      for (int i = 0; i < 8; i++) begin
         logic [20:0] v;
         v = VEC[i];
         run_hit(v[20:17], int'(v[16:9]), int'(v[8:1]), v[0]);
      end

      // R9 overflow: five hits fill every slot, the sixth is dropped
      for (int k = 0; k <= 60; k++) begin
         @(negedge clk);
         lat  = 8'd40;
         trig = 1'b0;
         disc = (k <= 8 && (k % 2) == 0) ? 4'b0001 : ((k == 10) ? 4'b0010 : 4'b0000);
         if (k == 9)  chk("R9 fifth hit accepted", {31'd0, ovf}, 32'd0);
         if (k == 11) chk("R9 overflow pulse", {31'd0, ovf}, 32'd1);
         if (k == 12) chk("R9 overflow one cycle", {31'd0, ovf}, 32'd0);
         if (k == 60) chk("R6 expired slots not ready", {31'd0, rd_ready}, 32'd0);
      end
      // R3 slots reusable, dropped pixel not stored
      run_hit(4'b0100, 2, 3, 1'b1);

      // R8 R7 R11 R3: A on pixel0 latency 10 (slot 0), B on pixel1 latency 2 (slot 1)
      for (int k = 0; k <= 15; k++) begin
         @(negedge clk);
         disc   = (k == 0) ? 4'b0001 : ((k == 1) ? 4'b0010 : 4'b0000);
         lat    = (k == 0) ? 8'd10 : 8'd2;
         trig   = (k == 4 || k == 11);
         rd_ack = 1'b0;
         if (k == 6) begin
            chk("R5 B ready", {31'd0, rd_ready}, 32'd1);
            chk("R3 B in pixel1", {28'd0, rd_mask}, 32'h2);
         end
         if (k == 10) chk("R7 R11 B held, A not early", {16'd0, rd_tot}, 32'h0010);
         if (k == 12) begin
            chk("R8 lower slot shown first", {28'd0, rd_mask}, 32'h1);
            chk("R8 lower slot tot", {16'd0, rd_tot}, 32'h0001);
            rd_ack = 1'b1;
         end
         if (k == 13) begin
            chk("R7 B kept until read", {28'd0, rd_mask}, 32'h2);
            rd_ack = 1'b1;
         end
         if (k == 14) chk("R7 all read", {31'd0, rd_ready}, 32'd0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule